// File: doc/BRIEF.md
# Cascadable Shift-and-Store Register

This block is a serial-in, parallel-out shift register followed by a parallel storage register of the same width. Serial data enters on the rising edge of a dedicated shift clock. The storage register has its own clock and copies the whole shift register in one step on that edge. The parallel outputs therefore change only when a new word is committed, while new data shifts in behind them.

Each register has its own active-low clear. Each clear acts asynchronously and does not touch the other register. The last shift stage drives a cascade output that can feed the serial input of the next block. A chain of blocks on common clocks and clears then acts as one long shift register with one wide storage word. The two clocks are independent domains. If both are driven from one signal, the storage register always holds the shift contents from the previous edge.

Top module: `cascade_shift_store`

## Requirements
- R1: On a rising shift clock edge with `shift_clr_n` high, stage 0 loads `ser_in` and each stage k (k ≥ 1) loads the previous value of stage k-1.
- R2: While `shift_clr_n` is low, all shift stages and `casc_out` are 0. This takes effect without any clock edge, and shift clock edges during the clear have no effect.
- R3: While `store_clr_n` is low, `par_out` is 0. This takes effect without any clock edge, and storage clock edges during the clear have no effect.
- R4: On a rising storage clock edge with `store_clr_n` high, `par_out` takes the whole shift register contents in parallel. Bit k of `par_out` is shift stage k. At all other times `par_out` holds its value.
- R5: `casc_out` is the last shift stage (stage WIDTH-1). A bit shifted in reaches `casc_out` after exactly WIDTH shift edges.
- R6: The clears are independent. A shift clear leaves `par_out` unchanged, and a storage clear leaves the shift contents and `casc_out` unchanged.
- R7: When both clocks rise together, `par_out` receives the shift contents from just before that edge.
- R8: N blocks chained through `casc_out` → `ser_in` on common clocks and clears behave as one N×WIDTH-bit shift-and-store register. The first block holds the least significant stages.
- R9: The register width is the parameter WIDTH (default 8, valid range 2 to 64), and every behaviour above holds for any width in that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift register clock, rising edge |
| store_clk | input | 1 | Storage register clock, rising edge |
| shift_clr_n | input | 1 | Asynchronous active-low clear of the shift register |
| store_clr_n | input | 1 | Asynchronous active-low clear of the storage register |
| ser_in | input | 1 | Serial data into stage 0 |
| par_out | output | WIDTH | Storage register contents |
| casc_out | output | 1 | Last shift stage, used for cascading |

## Verification
The bench builds three default-width (8) instances chained through the cascade output. This makes the 24-bit chain behaviour and the bit crossing between blocks observable. A fourth instance with WIDTH=3 shares the same stimulus. It shows that the cascade tap and the parallel load follow the parameter, and it reaches its cascade output after only three shifts. A reference model tracks both widths through directed and random mixes of separate edges, tied edges, and clear pulses that arrive with clock edges ignored.

// File: rtl/sss_pkg.sv
package sss_pkg;

  localparam int unsigned SSS_MAX_W = 64;

  // One shift step: bits move toward the top, din fills bit 0, result masked to w bits.
  function automatic logic [63:0] shift_word(input logic [63:0] cur,
                                             input logic        din,
                                             input int unsigned w);
    logic [63:0] mask;
    mask = (w >= SSS_MAX_W) ? '1 : ((64'd1 << w) - 64'd1);
    return ((cur << 1) | {63'd0, din}) & mask;
  endfunction

  // Tap of the cascade stage in a w-bit word.
  function automatic logic tail_bit(input logic [63:0] cur, input int unsigned w);
    return cur[w-1];
  endfunction

endpackage

// File: rtl/sss_shift_stage.sv
module sss_shift_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         din,
  output logic [W-1:0] q,
  output logic         tail
);
  import sss_pkg::*;

  localparam int unsigned PADW = SSS_MAX_W - W;

  logic [63:0] q_wide;
  logic [63:0] q_next_wide;

  generate
    if (PADW == 0) begin : g_full
      assign q_wide = q;
    end else begin : g_pad
      assign q_wide = {{PADW{1'b0}}, q};
    end
  endgenerate

  assign q_next_wide = shift_word(q_wide, din, W);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_next_wide[W-1:0];
  end

  assign tail = tail_bit(q_wide, W);

endmodule

// File: rtl/sss_store_stage.sv
module sss_store_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/cascade_shift_store.sv
module cascade_shift_store #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             shift_clk,
  input  logic             store_clk,
  input  logic             shift_clr_n,
  input  logic             store_clr_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] par_out,
  output logic             casc_out
);

  // Internal shift contents, named so the checker can observe them.
  logic [WIDTH-1:0] shift_q;
  logic             shift_tail;

  sss_shift_stage #(.W(WIDTH)) u_shift (
    .clk   (shift_clk),
    .clr_n (shift_clr_n),
    .din   (ser_in),
    .q     (shift_q),
    .tail  (shift_tail)
  );

  sss_store_stage #(.W(WIDTH)) u_store (
    .clk   (store_clk),
    .clr_n (store_clr_n),
    .d     (shift_q),
    .q     (par_out)
  );

  assign casc_out = shift_tail;

endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
  parameter int unsigned W = 8
) (
  input logic         shift_clk,
  input logic         store_clk,
  input logic         shift_clr_n,
  input logic         store_clr_n,
  input logic         ser_in,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] par_out,
  input logic         casc_out
);

  AST_SHIFT_STEP: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
    1'b1 |=> shift_q == {$past(shift_q[W-2:0]), $past(ser_in)}); // R1

  AST_SHIFT_CLEARED: assert property (@(posedge shift_clk)
    !shift_clr_n |-> (shift_q == '0) && !casc_out); // R2

  AST_STORE_CLEARED: assert property (@(posedge store_clk)
    !store_clr_n |-> par_out == '0); // R3

  AST_STORE_LOAD: assert property (@(posedge store_clk) disable iff (!store_clr_n)
    1'b1 |=> par_out == $past(shift_q)); // R4

  AST_CASCADE_TAP: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
    1'b1 |=> casc_out == $past(shift_q[W-2])); // R5

endmodule

bind cascade_shift_store sss_checker #(.W(WIDTH)) u_chk (
  .shift_clk   (shift_clk),
  .store_clk   (store_clk),
  .shift_clr_n (shift_clr_n),
  .store_clr_n (store_clr_n),
  .ser_in      (ser_in),
  .shift_q     (shift_q),
  .par_out     (par_out),
  .casc_out    (casc_out)
);

// File: tb/cascade_shift_store_bench.sv
module cascade_shift_store_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic shift_clk = 1'b0, store_clk = 1'b0;
  logic shift_clr_n = 1'b1, store_clr_n = 1'b1;
  logic ser_in = 1'b0;

  logic [7:0] p0, p1, p2;
  logic       c0, c1, c2;
  logic [2:0] pn;
  logic       cn;

  cascade_shift_store #(.WIDTH(8)) u_cascade_shift_store (
    .shift_clk(shift_clk), .store_clk(store_clk), .shift_clr_n(shift_clr_n),
    .store_clr_n(store_clr_n), .ser_in(ser_in), .par_out(p0), .casc_out(c0));
  cascade_shift_store #(.WIDTH(8)) u_mid (
    .shift_clk(shift_clk), .store_clk(store_clk), .shift_clr_n(shift_clr_n),
    .store_clr_n(store_clr_n), .ser_in(c0), .par_out(p1), .casc_out(c1));
  cascade_shift_store #(.WIDTH(8)) u_last (
    .shift_clk(shift_clk), .store_clk(store_clk), .shift_clr_n(shift_clr_n),
    .store_clr_n(store_clr_n), .ser_in(c1), .par_out(p2), .casc_out(c2));
  cascade_shift_store #(.WIDTH(3)) u_narrow (
    .shift_clk(shift_clk), .store_clk(store_clk), .shift_clr_n(shift_clr_n),
    .store_clr_n(store_clr_n), .ser_in(ser_in), .par_out(pn), .casc_out(cn));

  // Reference model: 24-bit chain and 3-bit narrow block.
  logic [23:0] ms = '0, mst = '0;
  logic [2:0]  ns = '0, nst = '0;

  int nchk = 0;
  int nerr = 0;

  // Encoding {op[2:0], din}: op 0 shift, 1 store, 2 both tied, 3 shift clear, 4 store clear.
  localparam logic [3:0] VEC [16] = '{4'h1, 4'h0, 4'h1, 4'h1, 4'h2, 4'h5, 4'h4, 4'h6,
                                      4'h2, 4'h1, 4'h8, 4'h2, 4'h5, 4'h0, 4'h1, 4'h2};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic sh, input logic st);
    @(negedge clk);
    shift_clk = sh;
    store_clk = st;
    @(posedge clk);
    shift_clk = 1'b0;
    store_clk = 1'b0;
  endtask

  task automatic compare_all(input string tag);
    chk(tag, 64'(p0), 64'(mst[7:0]));
    chk(tag, 64'(c0), 64'(ms[7]));
    chk("R8", 64'({p2, p1, p0}), 64'(mst));
    chk("R8", 64'(c2), 64'(ms[23]));
    chk("R9", 64'(pn), 64'(nst));
    chk("R9", 64'(cn), 64'(ns[2]));
  endtask

  task automatic do_op(input logic [2:0] op, input logic din);
    string tag;
    ser_in = din;
    case (op)
      3'd0: begin
        pulse(1'b1, 1'b0);
        ms = {ms[22:0], din}; ns = {ns[1:0], din}; tag = "R1";
      end
      3'd1: begin
        pulse(1'b0, 1'b1);
        mst = ms; nst = ns; tag = "R4";
      end
      3'd2: begin
        pulse(1'b1, 1'b1);
        mst = ms; nst = ns;
        ms = {ms[22:0], din}; ns = {ns[1:0], din}; tag = "R7";
      end
      3'd3: begin
        @(negedge clk); #1;
        shift_clr_n = 1'b0;
        #1;
        chk("R2", 64'({c0, c1, c2, cn}), 64'd0);
        pulse(1'b1, 1'b0);
        ms = '0; ns = '0;
        @(negedge clk);
        shift_clr_n = 1'b1;
        tag = "R6";
      end
      default: begin
        @(negedge clk); #1;
        store_clr_n = 1'b0;
        #1;
        chk("R3", 64'({p2, p1, p0, pn}), 64'd0);
        pulse(1'b0, 1'b1);
        mst = '0; nst = '0;
        @(negedge clk);
        store_clr_n = 1'b1;
        tag = "R6";
      end
    endcase
    #2;
    compare_all(tag);
  endtask

  initial begin
    #1_000_000;
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #2;
    shift_clr_n = 1'b0;
    store_clr_n = 1'b0;
    #20;
    chk("R2", 64'({c0, c1, c2, cn}), 64'd0);
    chk("R3", 64'({p2, p1, p0, pn}), 64'd0);
    @(negedge clk);
    shift_clr_n = 1'b1;
    store_clr_n = 1'b1;
    #2;

    // R5 / R9: a lone 1 reaches the cascade tap after exactly WIDTH shifts.
    for (int i = 0; i < 8; i++) begin
      do_op(3'd0, i == 0);
      if (i == 1) chk("R9", 64'(cn), 64'd0);
      if (i == 2) chk("R9", 64'(cn), 64'd1);
      if (i == 6) chk("R5", 64'(c0), 64'd0);
      if (i == 7) chk("R5", 64'(c0), 64'd1);
    end

    for (int i = 0; i < 16; i++) do_op(VEC[i][3:1], VEC[i][0]);

    for (int i = 0; i < 300; i++) begin
      int r;
      logic [2:0] op;
      r = int'($urandom_range(0, 9));
      op = (r < 4) ? 3'd0 : (r < 6) ? 3'd1 : (r < 8) ? 3'd2 : (r == 8) ? 3'd3 : 3'd4;
      do_op(op, 1'($urandom_range(0, 1)));
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule